// File: doc/BRIEF.md
# Rate-Trimmed Nanosecond Time-of-Day Counter

This block keeps a 64-bit time of day in nanoseconds. The count does not advance by a fixed amount on every reference clock. Instead, a 32-bit phase accumulator adds a programmable rate word on each reference cycle. Every time the accumulator wraps past 2^32, the time count grows by a programmable tick period in nanoseconds.

The rate word is nominally ceil(2^32 * nominal_freq / reference_freq), and the tick period is 1e9 / nominal_freq. Software trims the clock by nudging the rate word; a step of one in that word is a part-per-billion-scale change in rate.

Software reaches the block through a small 32-bit register interface: a control word, the rate word, a prescale word and the two halves of the time. Time is set by writing the low half and then the high half, and read by reading the low half and then the high half. The split access is arranged so that the 64-bit value stays coherent while the counter runs. The live count is also brought out for on-chip consumers.

Top module: `tod_rate_counter`

## Requirements
- R1: After reset the time count and the phase accumulator are zero, the enable bit is clear, the period field holds PERIOD_RST, the rate word holds RATE_RST, the prescale word holds PRSC_RST, and reg_rdata is zero.
- R2: On each clock edge where the enable bit is set and no time load takes place, the phase becomes (phase + rate) mod 2^32, and the time count grows by the period field exactly when that sum carries out of bit 31.
- R3: While the enable bit (control bit 0) is clear, neither the time count nor the phase changes; writing zero to the control word stops the counter.
- R4: A write to address 3 (time low) only places the data in a staging word; the time count is unchanged by it.
- R5: A write to address 4 (time high) loads the time count with {write data, staging word} at that edge and clears the phase; the load takes the place of any advance in that cycle.
- R6: A read of address 3 returns the current low 32 bits and captures the high 32 bits at the same edge; a later read of address 4 returns that captured value, even if the count has since carried into its high half.
- R7: Read data is registered: reg_rdata takes its new value at the edge where reg_rd is sampled high, and holds it in all other cycles.
- R8: Address 0 (control: bit 0 enable, bits 15:8 period), address 1 (rate word) and address 2 (prescale, low PRSC_W bits) read back what was written. Unused control bits read as zero, and unmapped addresses read as zero.
- R9: A rewrite of the rate word takes effect from the next advance onward. It neither resets the phase nor changes the time count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| tod_ns | output | 64 | Live nanosecond time count |

## Verification
A register write takes effect at the edge where the strobe is sampled, and the counter uses a new rate word or period from the next edge on. A time load appears on tod_ns right after its edge. Read data appears after the edge where the read strobe is sampled, so the bench drives each strobe on a falling edge and samples reg_rdata and tod_ns on the next falling edge. A reference model in the bench steps the phase and count on each rising edge, but only after the enable write that the bench itself has issued. It treats the edge of a disabling write as one more advance, so every comparison lines up with the design's own edge count.

// File: rtl/tod_rate_pkg.sv
package tod_rate_pkg;

  localparam int unsigned WORD_W = 32;
  localparam int unsigned TIME_W = 64;

  typedef enum logic [2:0] {
    A_CTRL   = 3'd0,
    A_RATE   = 3'd1,
    A_PRSC   = 3'd2,
    A_TIME_L = 3'd3,
    A_TIME_H = 3'd4
  } reg_addr_e;

  typedef struct packed {
    logic              carry;
    logic [WORD_W-1:0] sum;
  } phase_step_t;

  // One step of the fractional accumulator.
  function automatic phase_step_t phase_step(input logic [WORD_W-1:0] ph,
                                             input logic [WORD_W-1:0] rate);
    logic [WORD_W:0] wide;
    phase_step_t     r;
    wide    = {1'b0, ph} + {1'b0, rate};
    r.carry = wide[WORD_W];
    r.sum   = wide[WORD_W-1:0];
    return r;
  endfunction

  // Advance of the time count by one tick period.
  function automatic logic [TIME_W-1:0] tick_add(input logic [TIME_W-1:0] t,
                                                 input logic [15:0]       per);
    return t + {{(TIME_W-16){1'b0}}, per};
  endfunction

endpackage

// File: rtl/tod_phase_acc.sv
module tod_phase_acc
  import tod_rate_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              clr,
  input  logic [WORD_W-1:0] rate,
  output logic              carry,
  output logic [WORD_W-1:0] phase
);

  phase_step_t nxt;

  always_comb begin
    nxt   = phase_step(phase, rate);
    carry = run && !clr && nxt.carry;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       phase <= '0;
    else if (clr)     phase <= '0;
    else if (run)     phase <= nxt.sum;
  end

  // R5: a load clears the fraction
  a_r5_phase_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> phase == '0);

  // R3: phase frozen while stopped
  a_r3_phase_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !clr) |=> $stable(phase));

  // R2: phase moves by the rate word, modulo 2^32
  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !clr) |=> phase == WORD_W'($past(phase) + $past(rate)));

endmodule

// File: rtl/tod_ns_count.sv
module tod_ns_count
  import tod_rate_pkg::*;
#(
  parameter int unsigned PERIOD_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [PERIOD_W-1:0] period,
  input  logic                load,
  input  logic [TIME_W-1:0]   load_val,
  output logic [TIME_W-1:0]   count
);

  logic [15:0] per16;

  always_comb per16 = 16'(period);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     count <= '0;
    else if (load)  count <= load_val;
    else if (tick)  count <= tick_add(count, per16);
  end

  // R5: load wins and lands exactly
  a_r5_load: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> count == $past(load_val));

  // R2: carry adds one period
  a_r2_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && tick) |=> count == $past(count) + TIME_W'($past(period)));

  // R3: no carry, no load, no change
  a_r3_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !tick) |=> $stable(count));

endmodule

// File: rtl/tod_reg_if.sv
module tod_reg_if
  import tod_rate_pkg::*;
#(
  parameter int unsigned         ADDR_W     = 3,
  parameter int unsigned         PERIOD_W   = 8,
  parameter int unsigned         PRSC_W     = 16,
  parameter logic [PERIOD_W-1:0] PERIOD_RST = 8'd10,
  parameter logic [WORD_W-1:0]   RATE_RST   = 32'hCCCC_CCCD,
  parameter logic [PRSC_W-1:0]   PRSC_RST   = 16'd2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [WORD_W-1:0]   reg_wdata,
  output logic [WORD_W-1:0]   reg_rdata,
  input  logic [TIME_W-1:0]   count,
  output logic                run,
  output logic [PERIOD_W-1:0] period,
  output logic [WORD_W-1:0]   rate,
  output logic                load,
  output logic [TIME_W-1:0]   load_val
);

  localparam int unsigned PER_LSB = 8;
  localparam int unsigned PER_MSB = PER_LSB + PERIOD_W - 1;

  logic [WORD_W-1:0] stage_lo;
  logic [WORD_W-1:0] hi_snap;
  logic [PRSC_W-1:0] prsc;
  logic [WORD_W-1:0] ctrl_view;
  logic [WORD_W-1:0] rd_mux;

  logic wr_ctrl, wr_rate, wr_prsc, wr_lo, wr_hi, rd_lo;

  always_comb begin
    wr_ctrl = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
    wr_rate = reg_wr && (reg_addr == ADDR_W'(A_RATE));
    wr_prsc = reg_wr && (reg_addr == ADDR_W'(A_PRSC));
    wr_lo   = reg_wr && (reg_addr == ADDR_W'(A_TIME_L));
    wr_hi   = reg_wr && (reg_addr == ADDR_W'(A_TIME_H));
    rd_lo   = reg_rd && (reg_addr == ADDR_W'(A_TIME_L));
    load     = wr_hi;
    load_val = {reg_wdata, stage_lo};
  end

  always_comb begin
    ctrl_view                   = '0;
    ctrl_view[0]                = run;
    ctrl_view[PER_MSB:PER_LSB]  = period;
  end

  always_comb begin
    unique case (reg_addr)
      ADDR_W'(A_CTRL):   rd_mux = ctrl_view;
      ADDR_W'(A_RATE):   rd_mux = rate;
      ADDR_W'(A_PRSC):   rd_mux = WORD_W'(prsc);
      ADDR_W'(A_TIME_L): rd_mux = count[WORD_W-1:0];
      ADDR_W'(A_TIME_H): rd_mux = hi_snap;
      default:           rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      period   <= PERIOD_RST;
      rate     <= RATE_RST;
      prsc     <= PRSC_RST;
      stage_lo <= '0;
    end else begin
      if (wr_ctrl) begin
        run    <= reg_wdata[0];
        period <= reg_wdata[PER_MSB:PER_LSB];
      end
      if (wr_rate) rate     <= reg_wdata;
      if (wr_prsc) prsc     <= reg_wdata[PRSC_W-1:0];
      if (wr_lo)   stage_lo <= reg_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      reg_rdata <= '0;
      hi_snap   <= '0;
    end else if (reg_rd) begin
      reg_rdata <= rd_mux;
      if (rd_lo) hi_snap <= count[TIME_W-1:WORD_W];
    end
  end

  // R7: read data holds without a read strobe
  a_r7_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !reg_rd |=> $stable(reg_rdata));

  // R6: a low read captures the upper half of the count
  a_r6_hi_capture: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lo |=> hi_snap == $past(count[TIME_W-1:WORD_W]));

  // R9: a rate write lands without touching the staging word
  a_r9_rate_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_rate |=> (rate == $past(reg_wdata)) && $stable(stage_lo));

endmodule

// File: rtl/tod_rate_counter.sv
module tod_rate_counter
  import tod_rate_pkg::*;
#(
  parameter int unsigned         ADDR_W     = 3,
  parameter int unsigned         PERIOD_W   = 8,
  parameter int unsigned         PRSC_W     = 16,
  parameter logic [PERIOD_W-1:0] PERIOD_RST = 8'd10,
  parameter logic [31:0]         RATE_RST   = 32'hCCCC_CCCD,
  parameter logic [PRSC_W-1:0]   PRSC_RST   = 16'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic [63:0]       tod_ns
);

  logic                run;
  logic [PERIOD_W-1:0] period;
  logic [WORD_W-1:0]   rate;
  logic                load;
  logic [TIME_W-1:0]   load_val;
  logic                carry;
  logic [WORD_W-1:0]   phase;

  tod_reg_if #(
    .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W), .PRSC_W(PRSC_W),
    .PERIOD_RST(PERIOD_RST), .RATE_RST(RATE_RST), .PRSC_RST(PRSC_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .count(tod_ns), .run(run), .period(period), .rate(rate),
    .load(load), .load_val(load_val)
  );

  tod_phase_acc u_phase (
    .clk(clk), .rst_n(rst_n), .run(run), .clr(load),
    .rate(rate), .carry(carry), .phase(phase)
  );

  tod_ns_count #(.PERIOD_W(PERIOD_W)) u_count (
    .clk(clk), .rst_n(rst_n), .tick(carry), .period(period),
    .load(load), .load_val(load_val), .count(tod_ns)
  );

  // R4: a low-half write alone never moves the count while stopped
  a_r4_stage_only: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(A_TIME_L) && !run) |=> $stable(tod_ns));

  // R3: stopped timer keeps the time unless loaded
  a_r3_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !load) |=> $stable(tod_ns));

endmodule

// File: tb/tod_rate_counter_tb.sv
module tod_rate_counter_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [63:0] tod_ns;

  int n_run = 0;
  int n_fail = 0;

  // bench model of the time base
  logic        m_en = 1'b0;
  logic [31:0] m_rate = 32'hCCCC_CCCD;
  logic [7:0]  m_per = 8'd10;
  logic [31:0] m_ph = '0;
  logic [63:0] m_t = '0;

  always #4 clk = ~clk;

  tod_rate_counter u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .tod_ns(tod_ns)
  );

  always @(posedge clk) begin
    if (m_en) begin
      logic [32:0] s;
      s    = {1'b0, m_ph} + {1'b0, m_rate};
      m_ph = s[31:0];
      if (s[32]) m_t = m_t + {56'd0, m_per};
    end
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    case (a)
      3'd0: begin m_en = d[0]; m_per = d[15:8]; end
      3'd1: m_rate = d;
      3'd4: begin m_t = {d, m_t_stage}; m_ph = '0; end
      3'd3: m_t_stage = d;
      default: ;
    endcase
  endtask
  logic [31:0] m_t_stage = '0;

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    reg_rd = 1'b1; reg_addr = a;
    @(negedge clk);
    reg_rd = 1'b0;
    v = reg_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    check("R1 tod", tod_ns, 64'd0);
    check("R1 rdata", {32'd0, reg_rdata}, 64'd0);
    rd(3'd0, v); check("R1 ctrl", {32'd0, v}, 64'h0000_0A00);
    rd(3'd1, v); check("R1 rate", {32'd0, v}, 64'hCCCC_CCCD);
    rd(3'd2, v); check("R1 prsc", {32'd0, v}, 64'd2);
    idle(3);     check("R1 stopped", tod_ns, 64'd0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(3'd0, 32'hFFFF_1E00);
    rd(3'd0, v); check("R8 ctrl mask", {32'd0, v}, 64'h0000_1E00);
    wr(3'd1, 32'h4000_0000);
    rd(3'd1, v); check("R8 rate", {32'd0, v}, 64'h4000_0000);
    wr(3'd2, 32'hABCD_1234);
    rd(3'd2, v); check("R8 prsc width", {32'd0, v}, 64'h0000_1234);
    rd(3'd6, v); check("R8 unmapped", {32'd0, v}, 64'd0);
    idle(2);     check("R7 rdata holds", {32'd0, reg_rdata}, 64'd0);
  endtask

  task automatic t_stage_load();
    logic [31:0] v;
    wr(3'd3, 32'h1111_2222);
    check("R4 low write no effect", tod_ns, 64'd0);
    wr(3'd4, 32'h0000_0033);
    check("R5 load", tod_ns, 64'h0000_0033_1111_2222);
    rd(3'd3, v); check("R6 low", {32'd0, v}, 64'h1111_2222);
    rd(3'd4, v); check("R6 high", {32'd0, v}, 64'h33);
  endtask

  task automatic t_rate();
    // rate 2^30: one carry per 4 steps; 10 steps -> 2 carries of 30 ns
    wr(3'd3, 32'd1000); wr(3'd4, 32'd0);
    wr(3'd0, 32'h0000_1E01);
    idle(9);
    wr(3'd0, 32'h0000_1E00);
    check("R2 quarter rate", tod_ns, 64'd1060);
    check("R2 model", tod_ns, m_t);
    // near-third rate with a 7 ns period
    wr(3'd1, 32'h5555_5556);
    wr(3'd3, 32'd0); wr(3'd4, 32'd5);
    wr(3'd0, 32'h0000_0701);
    idle(20);
    wr(3'd0, 32'h0000_0700);
    check("R2 third rate", tod_ns, m_t);
    idle(4);
    check("R3 frozen", tod_ns, m_t);
  endtask

  task automatic t_coherent();
    logic [31:0] lo, hi;
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd3, 32'hFFFF_FFE0); wr(3'd4, 32'd7);
    wr(3'd0, 32'h0000_1001);
    rd(3'd3, lo);
    idle(5);
    rd(3'd4, hi);
    check("R6 live low", {32'd0, lo}, 64'hFFFF_FFE0);
    check("R6 captured high", {32'd0, hi}, 64'd7);
    check("R2 wrapped", tod_ns, m_t);
  endtask

  task automatic t_load_running();
    wr(3'd3, 32'h0000_0100);
    wr(3'd4, 32'h0000_0002);
    check("R5 load overrides advance", tod_ns, 64'h0000_0002_0000_0100);
    idle(6);
    wr(3'd0, 32'h0000_1000);
    check("R5 phase cleared", tod_ns, m_t);
  endtask

  task automatic t_rate_change();
    wr(3'd1, 32'h6000_0000);
    wr(3'd3, 32'd0); wr(3'd4, 32'd0);
    wr(3'd0, 32'h0000_0401);
    idle(4);
    wr(3'd1, 32'hA000_0000);
    check("R9 no count change", tod_ns, m_t);
    idle(7);
    wr(3'd0, 32'h0000_0400);
    check("R9 new rate", tod_ns, m_t);
  endtask

  initial begin
    fork
      begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_readback();
        t_stage_load();
        t_rate();
        t_coherent();
        t_load_running();
        t_rate_change();
      end
      begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule